// File: doc/BRIEF.md
# I2C Port Expander Target Sequencer

This block is the bus-side controller of an 8-bit port expander that acts as a target on an I2C bus. It samples the raw SCL and SDA lines with a system clock and finds START and STOP conditions in them. It collects the address byte and answers only when the low address bits match the levels on three strap pins, so up to eight expanders can share one bus. It acknowledges by enabling an open-drain pull-down on SDA.

After a write address, the first byte always programs the per-pin direction register. Every later byte in the same transfer updates the output latch. After a read address, the block pulses a capture strobe for the external input latch at each byte boundary. It then shifts the captured value out, most significant bit first, for as long as the controller keeps acknowledging. Changing direction takes a new START followed by the address again.

The block does not contain the port pins or the latches. It drives a shared byte bus with two load strobes and one capture strobe, and it reads the input latch back on `rd_data_i`.

Top module: `xpdr_i2c_seq`

## Requirements
- R1: After reset `sda_oe_o` is 0 and none of `dir_load_o`, `out_load_o` or `in_sample_o` is asserted.
- R2: An address byte whose upper seven bits, sent MSB first, equal 0111 followed by `strap_i[2:0]` is acknowledged. The block holds `sda_oe_o` at 1 through the 9th SCL clock. Bit 0 of the address byte selects the transfer: 0 is write, 1 is read.
- R3: On an address mismatch the block does not acknowledge. It ignores all further bytes, giving no acknowledge and no strobe, until the next START.
- R4: In a write transfer, the first byte after the address is acknowledged and produces a single `dir_load_o` pulse with that byte on `wr_byte_o`.
- R5: In a write transfer, every byte after the direction byte is acknowledged and produces a single `out_load_o` pulse with that byte on `wr_byte_o`. Any number of such bytes may follow.
- R6: In a read transfer, each data byte sent on SDA is the `rd_data_i` value captured at the previous `in_sample_o` pulse, sent MSB first. Bytes continue while the controller acknowledges.
- R7: In a read transfer, `in_sample_o` pulses once after the 8th SCL falling edge of the address byte and once after the 8th SCL falling edge of each data byte.
- R8: A controller NACK after a read byte ends the transfer. SDA stays released and no strobe is issued until the next START.
- R9: A START seen during a byte abandons that byte and restarts address reception. A following write transfer again treats its first byte as the direction byte.
- R10: `sda_oe_o` changes only while SCL is low. Each strobe lasts exactly one clock cycle and is issued while SCL is low.
- R11: A STOP returns the block to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| strap_i | input | 3 | Strap pins giving the low three address bits |
| rd_data_i | input | 8 | Contents of the external input latch |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| dir_load_o | output | 1 | One-cycle load strobe for the direction register |
| out_load_o | output | 1 | One-cycle load strobe for the output latch |
| wr_byte_o | output | 8 | Received byte, valid with either load strobe |
| in_sample_o | output | 1 | One-cycle capture strobe for the input latch |

## Verification
A corrupted bit counter or sequencer state shows at the ports within one byte period. An acknowledge lands on the wrong SCL clock, a read byte comes out shifted, or a load strobe arrives early, late or with the wrong kind. A first-byte flag that survives an aborted transfer shows up on the next write as an output-latch load where a direction load is expected. A stale acknowledge or NACK state shows as SDA pulled low, or as a capture strobe, in a byte period where the bus should be left alone. The scoreboard catches each of these in the byte where it happens.

// File: rtl/xpdr_pkg.sv
package xpdr_pkg;
  localparam int DATA_W  = 8;
  localparam int STRAP_W = 3;
  localparam int ADDR_W  = 7;
  localparam logic [ADDR_W-STRAP_W-1:0] ADDR_HI = 4'b0111;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_HOLD
  } seq_state_e;
endpackage

// File: rtl/xpdr_sync.sv
module xpdr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/xpdr_bus_cond.sv
module xpdr_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_i;
      sda_d <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_d;
  assign scl_fall_o = ~scl_i & scl_d;
  // SDA edges only count as conditions while SCL stays high
  assign start_o    = scl_i & scl_d & sda_d & ~sda_i;
  assign stop_o     = scl_i & scl_d & ~sda_d & sda_i;
endmodule

// File: rtl/xpdr_seq.sv
module xpdr_seq
  import xpdr_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int SW  = STRAP_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          sda_i,
  input  logic [SW-1:0] strap_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          sda_oe_o,
  output logic          dir_load_o,
  output logic          out_load_o,
  output logic [DW-1:0] wr_byte_o,
  output logic          in_sample_o
);
  localparam int CNT_W = $clog2(DW + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DW);

  seq_state_e    state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DW-1:0] sr_q;
  logic          rw_q, first_q, nack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      sr_q        <= '0;
      rw_q        <= 1'b0;
      first_q     <= 1'b0;
      nack_q      <= 1'b0;
      sda_oe_o    <= 1'b0;
      dir_load_o  <= 1'b0;
      out_load_o  <= 1'b0;
      in_sample_o <= 1'b0;
      wr_byte_o   <= '0;
    end else begin
      dir_load_o  <= 1'b0;
      out_load_o  <= 1'b0;
      in_sample_o <= 1'b0;
      if (start_i) begin
        state_q  <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: begin
            if (scl_rise_i) begin
              sr_q  <= {sr_q[DW-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == FULL) begin
              if (sr_q[DW-1:1] == {ADDR_HI, strap_i}) begin
                sda_oe_o    <= 1'b1;
                rw_q        <= sr_q[0];
                in_sample_o <= sr_q[0];
                state_q     <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (rw_q) begin
                sr_q     <= rd_data_i;
                sda_oe_o <= ~rd_data_i[DW-1];
                state_q  <= ST_RD_BYTE;
              end else begin
                sda_oe_o <= 1'b0;
                first_q  <= 1'b1;
                state_q  <= ST_WR_BYTE;
              end
            end
          end
          ST_WR_BYTE: begin
            if (scl_rise_i) begin
              sr_q  <= {sr_q[DW-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == FULL) begin
              sda_oe_o   <= 1'b1;
              wr_byte_o  <= sr_q;
              dir_load_o <= first_q;
              out_load_o <= ~first_q;
              first_q    <= 1'b0;
              state_q    <= ST_WR_ACK;
            end
          end
          ST_WR_ACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              cnt_q    <= '0;
              state_q  <= ST_WR_BYTE;
            end
          end
          ST_RD_BYTE: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i) begin
              if (cnt_q == FULL) begin
                sda_oe_o    <= 1'b0;
                in_sample_o <= 1'b1;
                state_q     <= ST_RD_ACK;
              end else begin
                sr_q     <= {sr_q[DW-2:0], 1'b0};
                sda_oe_o <= ~sr_q[DW-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) begin
              nack_q <= sda_i;
            end else if (scl_fall_i) begin
              if (nack_q) begin
                state_q <= ST_HOLD;
              end else begin
                sr_q     <= rd_data_i;
                sda_oe_o <= ~rd_data_i[DW-1];
                cnt_q    <= '0;
                state_q  <= ST_RD_BYTE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/xpdr_i2c_seq.sv
module xpdr_i2c_seq
  import xpdr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [DATA_W-1:0]  rd_data_i,
  output logic               sda_oe_o,
  output logic               dir_load_o,
  output logic               out_load_o,
  output logic [DATA_W-1:0]  wr_byte_o,
  output logic               in_sample_o
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lines, sync_lines;
  logic scl_rise, scl_fall, start_det, stop_det;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    xpdr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (raw_lines[g]),
      .q_o    (sync_lines[g])
    );
  end

  xpdr_bus_cond u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (sync_lines[1]),
    .sda_i      (sync_lines[0]),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  xpdr_seq #(.DW(DATA_W), .SW(STRAP_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_det),
    .stop_i      (stop_det),
    .sda_i       (sync_lines[0]),
    .strap_i     (strap_i),
    .rd_data_i   (rd_data_i),
    .sda_oe_o    (sda_oe_o),
    .dir_load_o  (dir_load_o),
    .out_load_o  (out_load_o),
    .wr_byte_o   (wr_byte_o),
    .in_sample_o (in_sample_o)
  );
endmodule

// File: rtl/xpdr_i2c_seq_chk.sv
module xpdr_i2c_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_oe_o,
  input logic dir_load_o,
  input logic out_load_o,
  input logic in_sample_o
);
  // R10: drive changes only while SCL is low
  a_r10_oe_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);

  // R10: strobes only while SCL is low
  a_r10_strobe_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_load_o || out_load_o || in_sample_o) |-> !scl_i);

  // R4
  a_r4_dir_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_load_o |=> !dir_load_o);

  // R5
  a_r5_out_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_load_o |=> !out_load_o);

  // R7
  a_r7_sample_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_sample_o |=> !in_sample_o);

  // R10
  a_r10_strobes_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dir_load_o, out_load_o, in_sample_o}));
endmodule

bind xpdr_i2c_seq xpdr_i2c_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_i       (scl_i),
  .sda_oe_o    (sda_oe_o),
  .dir_load_o  (dir_load_o),
  .out_load_o  (out_load_o),
  .in_sample_o (in_sample_o)
);

// File: tb/xpdr_i2c_seq_test.sv
module xpdr_i2c_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam logic [1:0] K_DIR = 2'd0, K_OUT = 2'd1, K_SMP = 2'd2;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_drv = 1'b1;
  logic [7:0] pins = 8'h00, latch;
  logic sda_oe, dir_load, out_load, in_sample;
  logic [7:0] wr_byte;
  wire  sda_line = sda_drv & ~sda_oe;

  int n_chk = 0, n_fail = 0, r10_viol = 0;
  bit done = 1'b0;
  logic [9:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  xpdr_i2c_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap_i(STRAP), .rd_data_i(latch), .sda_oe_o(sda_oe),
    .dir_load_o(dir_load), .out_load_o(out_load), .wr_byte_o(wr_byte),
    .in_sample_o(in_sample)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) latch <= 8'h00;
    else if (in_sample) latch <= pins;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  logic scl_prev = 1'b1, oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (scl && scl_prev && sda_oe != oe_prev) r10_viol++;
      if (dir_load || out_load || in_sample) begin
        logic [1:0] k;
        k = dir_load ? K_DIR : (out_load ? K_OUT : K_SMP);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3/R8", "unexpected strobe kind", k, 3);
        end else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          chk(k == e[9:8], "R4/R5/R7", "strobe kind", k, e[9:8]);
          if (k != K_SMP)
            chk(wr_byte == e[7:0], k == K_DIR ? "R4" : "R5", "byte", wr_byte, e[7:0]);
        end
      end
    end
    scl_prev = scl;
    oe_prev  = sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send_bit(input logic b, output logic l);
    sda_drv = b; tick(Q);
    scl = 1'b1; tick(Q);
    l = sda_line; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic start_cond();
    sda_drv = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    sda_drv = 1'b0; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic stop_cond();
    sda_drv = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    sda_drv = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic l;
    for (int i = 7; i >= 0; i--) send_bit(b[i], l);
    send_bit(1'b1, l);
    acked = ~l;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    logic l;
    for (int i = 7; i >= 0; i--) begin
      send_bit(1'b1, l);
      b[i] = l;
    end
    send_bit(~ack, l);
  endtask

  task automatic push(input logic [1:0] k, input logic [7:0] d);
    exp_q.push_back({k, d});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] rb;
    tick(3);
    chk(sda_oe == 1'b0, "R1", "sda_oe after reset", sda_oe, 0);
    chk({dir_load, out_load, in_sample} == 3'b000, "R1", "strobes in reset",
        {dir_load, out_load, in_sample}, 0);
    rst_n = 1'b1;
    tick(10);
    chk(sda_oe == 1'b0, "R1", "sda_oe idle", sda_oe, 0);

    // write transfer: direction byte then two output bytes
    start_cond();
    send_byte({4'b0111, STRAP, 1'b0}, a);
    chk(a, "R2", "write address ack", a, 1);
    push(K_DIR, 8'hA5);
    send_byte(8'hA5, a);
    chk(a, "R4", "direction byte ack", a, 1);
    push(K_OUT, 8'h3C);
    send_byte(8'h3C, a);
    chk(a, "R5", "data byte ack", a, 1);
    push(K_OUT, 8'hC3);
    send_byte(8'hC3, a);
    chk(a, "R5", "second data byte ack", a, 1);
    stop_cond();
    tick(4);
    chk(sda_oe == 1'b0, "R11", "sda released after stop", sda_oe, 0);
    chk(exp_q.size() == 0, "R5", "pending write strobes", exp_q.size(), 0);

    // address mismatch
    start_cond();
    send_byte({4'b0111, 3'b000, 1'b0}, a);
    chk(!a, "R3", "mismatch address ack", a, 0);
    send_byte(8'h55, a);
    chk(!a, "R3", "byte after mismatch ack", a, 0);
    stop_cond();

    // read transfer
    pins = 8'h96;
    start_cond();
    push(K_SMP, 8'h00);
    send_byte({4'b0111, STRAP, 1'b1}, a);
    chk(a, "R2", "read address ack", a, 1);
    pins = 8'h4D;
    push(K_SMP, 8'h00);
    recv_byte(1'b1, rb);
    chk(rb == 8'h96, "R6", "read byte 1", rb, 8'h96);
    pins = 8'h21;
    push(K_SMP, 8'h00);
    recv_byte(1'b1, rb);
    chk(rb == 8'h4D, "R6", "read byte 2", rb, 8'h4D);
    push(K_SMP, 8'h00);
    recv_byte(1'b0, rb);
    chk(rb == 8'h21, "R6", "read byte 3", rb, 8'h21);
    chk(exp_q.size() == 0, "R7", "pending sample strobes", exp_q.size(), 0);
    recv_byte(1'b1, rb);
    chk(rb == 8'hFF, "R8", "bus released after nack", rb, 8'hFF);
    stop_cond();

    // mid-byte START aborts, first byte is direction again
    start_cond();
    send_byte({4'b0111, STRAP, 1'b0}, a);
    chk(a, "R9", "address before abort", a, 1);
    for (int i = 0; i < 4; i++) send_bit(1'b0, a);
    start_cond();
    send_byte({4'b0111, STRAP, 1'b0}, a);
    chk(a, "R9", "address after restart", a, 1);
    push(K_DIR, 8'h0F);
    send_byte(8'h0F, a);
    chk(a, "R9", "direction byte after restart ack", a, 1);
    stop_cond();
    tick(20);

    chk(exp_q.size() == 0, "R9", "leftover expected strobes", exp_q.size(), 0);
    chk(r10_viol == 0, "R10", "sda_oe changes while SCL high", r10_viol, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule